// File: doc/BRIEF.md
# Receive Defect Change Interrupt Registers

This block turns changes in five receive-side defect indications of an E3 framer into latched, maskable interrupt events. Four of the indications are levels (alarm indication signal, loss of signal, loss of frame, out of frame). The block detects both their rising and their falling edges, so declaring a defect and clearing it both raise an event. The fifth indication is a one-cycle pulse that reports a change in framing alignment. Each event sets a sticky status bit, but only while its source is enabled. One shared active-low request line is low while any enabled source has a pending status bit.

Software reaches the block through a plain byte-wide register port. The port has an address, a write strobe, a read strobe, write data and combinational read data. There is no back-pressure: every strobe is taken in the cycle it is presented. Three registers are mapped on the port:

- an enable register;
- a status register that clears when read;
- a live-level register that shows the current defect inputs, so software can tell whether a change was a declaration or a clearance.

The live-level register also holds one writable bit that selects the loss-of-frame algorithm used by the framer.

Top module: `defect_irq_regs`

## Requirements
- R1: The enable register is at address 0x12. Bit 4 enables the alignment-change source, bit 3 out of frame, bit 2 loss of frame, bit 1 loss of signal and bit 0 alarm indication. A write stores bits 4..0, and a read returns them with bits 7..5 as 0.
- R2: The status register is at address 0x14 and uses the same bit positions as the enable register. Bits 7..5 read as 0, and writes to this address change nothing.
- R3: A rising or a falling edge on any of the four level inputs, or a high cycle on the alignment-change pulse input, sets the matching status bit at the next clock edge if that source is enabled.
- R4: irq_n is low exactly when some status bit 4..0 is 1 and its enable bit is also 1; otherwise irq_n is high.
- R5: A read strobe at address 0x14 returns the status value held before the read, and clears status bits 4..0 at the end of that cycle.
- R6: An enabled event in the same cycle as a status read wins: that status bit is 1 after the read.
- R7: An event whose enable bit is 0 is discarded. Its status bit stays 0, and enabling the source later does not raise the request.
- R8: The live-level register is at address 0x11. Bit 6 shows loss of frame, bit 5 out of frame, bit 4 loss of signal, bit 3 alarm indication and bit 0 far-end failure. Bits 2..1 read as 0.
- R9: Bit 7 of address 0x11 is a writable algorithm select. It reads back and drives lof_alg_sel.
- R10: A read of any other address returns 0.
- R11: Reset clears the enable bits, the status bits and the algorithm select, and holds irq_n high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ais_lvl | input | 1 | Alarm indication signal defect level |
| los_lvl | input | 1 | Loss of signal defect level |
| lof_lvl | input | 1 | Loss of frame defect level |
| oof_lvl | input | 1 | Out of frame defect level |
| far_fail_lvl | input | 1 | Far-end failure indication level (live view only) |
| align_chg_pulse | input | 1 | One-cycle pulse on a framing alignment change |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| lof_alg_sel | output | 1 | Loss-of-frame algorithm select |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest case to reach from the ports is an enabled defect edge arriving in the same cycle as the clearing read of the status register. The bench sets up a pending bit on one source. Then, at one falling clock edge, it toggles a second source's level and raises the read strobe. It checks that the read returns only the older bit and that the new bit and the request survive. The rest of the stimulus sweeps all 32 enable masks against every source and both edge directions, and all 32 combinations of live levels.

// File: rtl/defect_irq_pkg.sv
package defect_irq_pkg;
  localparam int BUS_W   = 8;
  localparam int NUM_LVL = 4;
  localparam int NUM_SRC = NUM_LVL + 1;

  localparam logic [BUS_W-1:0] ADDR_LIVE = 8'h11;
  localparam logic [BUS_W-1:0] ADDR_ENA  = 8'h12;
  localparam logic [BUS_W-1:0] ADDR_STAT = 8'h14;

  // status / enable bit positions
  localparam int SRC_AIS   = 0;
  localparam int SRC_LOS   = 1;
  localparam int SRC_LOF   = 2;
  localparam int SRC_OOF   = 3;
  localparam int SRC_ALIGN = 4;

  // live-level register bit positions
  localparam int LV_ALG  = 7;
  localparam int LV_LOF  = 6;
  localparam int LV_OOF  = 5;
  localparam int LV_LOS  = 4;
  localparam int LV_AIS  = 3;
  localparam int LV_FAR  = 0;
endpackage

// File: rtl/dirq_edge_detect.sv
module dirq_edge_detect #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] evt
);
  logic [N-1:0] prev_q;
  logic         armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= lvl;
      armed_q <= 1'b1;
    end
  end

  assign evt = lvl ^ prev_q;

  for (genvar g = 0; g < N; g++) begin : g_chk
    // R3: any level change against the previous cycle is an event
    assert_edge_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q && (lvl[g] != $past(lvl[g])) |-> evt[g]);
    // R3: a steady level raises no event
    assert_steady_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q && (lvl[g] == $past(lvl[g])) |-> !evt[g]);
  end
endmodule

// File: rtl/dirq_status_bank.sv
module dirq_status_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] en,
  input  logic         rd_clr,
  output logic [N-1:0] stat_q
);
  logic [N-1:0] set_v;
  logic [N-1:0] keep_v;

  assign set_v  = evt & en;
  assign keep_v = rd_clr ? '0 : stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= set_v | keep_v;
  end

  for (genvar g = 0; g < N; g++) begin : g_chk
    // R3 / R6: an enabled event always lands, read or not
    assert_event_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[g] && en[g]) |=> stat_q[g]);
    // R5: a read without a new event clears the bit
    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr && !(evt[g] && en[g])) |=> !stat_q[g]);
    // R7: without an enabled event a clear bit stays clear
    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_q[g] && !(evt[g] && en[g])) |=> !stat_q[g]);
    // status is sticky until a read
    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[g] && !rd_clr) |=> stat_q[g]);
  end
endmodule

// File: rtl/dirq_reg_file.sv
module dirq_reg_file
  import defect_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BUS_W-1:0]   bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic [NUM_SRC-1:0] stat_q,
  input  logic               ais_lvl,
  input  logic               los_lvl,
  input  logic               lof_lvl,
  input  logic               oof_lvl,
  input  logic               far_fail_lvl,
  output logic [NUM_SRC-1:0] en_q,
  output logic               alg_q,
  output logic               rd_clr
);
  logic wr_ena, wr_live;
  logic [BUS_W-1:0] live_v;
  logic unused_wbits;

  assign wr_ena  = bus_wr && (bus_addr == ADDR_ENA);
  assign wr_live = bus_wr && (bus_addr == ADDR_LIVE);
  assign rd_clr  = bus_rd && (bus_addr == ADDR_STAT);
  assign unused_wbits = ^bus_wdata[LV_ALG-1:NUM_SRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      alg_q <= 1'b0;
    end else begin
      if (wr_ena)  en_q  <= bus_wdata[NUM_SRC-1:0];
      if (wr_live) alg_q <= bus_wdata[LV_ALG];
    end
  end

  always_comb begin
    live_v         = '0;
    live_v[LV_ALG] = alg_q;
    live_v[LV_LOF] = lof_lvl;
    live_v[LV_OOF] = oof_lvl;
    live_v[LV_LOS] = los_lvl;
    live_v[LV_AIS] = ais_lvl;
    live_v[LV_FAR] = far_fail_lvl;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        ADDR_LIVE: bus_rdata = live_v;
        ADDR_ENA:  bus_rdata = BUS_W'(en_q);
        ADDR_STAT: bus_rdata = BUS_W'(stat_q);
        default:   bus_rdata = '0;
      endcase
    end
  end

  // R1: a write to the enable address is stored
  assert_enable_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ena |=> en_q == $past(bus_wdata[NUM_SRC-1:0]));
  // R1: enable holds without a write to its address
  assert_enable_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ena |=> $stable(en_q));
  // R9: algorithm select changes only on a live-register write
  assert_alg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_live |=> $stable(alg_q));
endmodule

// File: rtl/defect_irq_regs.sv
module defect_irq_regs
  import defect_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ais_lvl,
  input  logic             los_lvl,
  input  logic             lof_lvl,
  input  logic             oof_lvl,
  input  logic             far_fail_lvl,
  input  logic             align_chg_pulse,
  input  logic [BUS_W-1:0] bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic             lof_alg_sel,
  output logic             irq_n
);
  logic [NUM_LVL-1:0] lvl_v;
  logic [NUM_LVL-1:0] lvl_evt;
  logic [NUM_SRC-1:0] evt_v;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] stat_q;
  logic               rd_clr;

  always_comb begin
    lvl_v          = '0;
    lvl_v[SRC_AIS] = ais_lvl;
    lvl_v[SRC_LOS] = los_lvl;
    lvl_v[SRC_LOF] = lof_lvl;
    lvl_v[SRC_OOF] = oof_lvl;
  end

  dirq_edge_detect #(.N(NUM_LVL)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (lvl_v),
    .evt   (lvl_evt)
  );

  assign evt_v = {align_chg_pulse, lvl_evt};

  dirq_status_bank #(.N(NUM_SRC)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt_v),
    .en     (en_q),
    .rd_clr (rd_clr),
    .stat_q (stat_q)
  );

  dirq_reg_file u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .stat_q       (stat_q),
    .ais_lvl      (ais_lvl),
    .los_lvl      (los_lvl),
    .lof_lvl      (lof_lvl),
    .oof_lvl      (oof_lvl),
    .far_fail_lvl (far_fail_lvl),
    .en_q         (en_q),
    .alg_q        (alg_q_w),
    .rd_clr       (rd_clr)
  );

  logic alg_q_w;
  assign lof_alg_sel = alg_q_w;
  assign irq_n       = ~|(stat_q & en_q);

  // R4: a low request always has a pending status bit behind it
  assert_irq_has_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> (stat_q != '0));
  // R4 / R7: with nothing enabled the request stays high
  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> irq_n);
endmodule

// File: tb/defect_irq_regs_test.sv
module defect_irq_regs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ais_lvl = 0, los_lvl = 0, lof_lvl = 0, oof_lvl = 0;
  logic       far_fail_lvl = 0, align_chg_pulse = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0;
  logic       bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_rdata;
  logic       lof_alg_sel, irq_n;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  defect_irq_regs uut (
    .clk(clk), .rst_n(rst_n), .ais_lvl(ais_lvl), .los_lvl(los_lvl),
    .lof_lvl(lof_lvl), .oof_lvl(oof_lvl), .far_fail_lvl(far_fail_lvl),
    .align_chg_pulse(align_chg_pulse), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .lof_alg_sel(lof_alg_sel), .irq_n(irq_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  // toggle one level source (0..3) or pulse the alignment input (4)
  task automatic fire(input int src);
    @(negedge clk);
    case (src)
      0: ais_lvl = ~ais_lvl;
      1: los_lvl = ~los_lvl;
      2: lof_lvl = ~lof_lvl;
      3: oof_lvl = ~oof_lvl;
      default: align_chg_pulse = 1;
    endcase
    @(negedge clk);
    align_chg_pulse = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11: reset state
    chk(irq_n == 1, "R11 irq_n", irq_n, 1);
    chk(lof_alg_sel == 0, "R11 alg", lof_alg_sel, 0);
    rd(8'h12, d); chk(d == 0, "R11 enable", d, 0);
    rd(8'h14, d); chk(d == 0, "R11 status", d, 0);

    // R1: enable readback, upper bits read 0
    wr(8'h12, 8'hFF); rd(8'h12, d); chk(d == 8'h1F, "R1 enable readback", d, 8'h1F);
    wr(8'h12, 8'h0A); rd(8'h12, d); chk(d == 8'h0A, "R1 enable readback", d, 8'h0A);

    // R10: unmapped read
    rd(8'h13, d); chk(d == 0, "R10 unmapped", d, 0);
    rd(8'h00, d); chk(d == 0, "R10 unmapped", d, 0);

    // R3 R4 R5 R7: sweep every mask, every source, both edge directions
    for (int m = 0; m < 32; m++) begin
      wr(8'h12, 8'(m));
      rd(8'h14, d);
      for (int s = 0; s < 5; s++) begin
        for (int dir = 0; dir < 2; dir++) begin
          bit on;
          on = m[s];
          fire(s);
          chk(irq_n == !on, "R4 irq after event", irq_n, !on);
          rd(8'h14, d);
          chk(d == (on ? (8'h1 << s) : 8'h0), on ? "R3 status set" : "R7 disabled discard",
              d, on ? (8'h1 << s) : 0);
          chk(irq_n == 1, "R5 irq after read", irq_n, 1);
          rd(8'h14, d);
          chk(d == 0, "R5 cleared on read", d, 0);
        end
      end
    end

    // R7: event while disabled, then enabling raises nothing
    wr(8'h12, 8'h00); fire(1); wr(8'h12, 8'h1F);
    chk(irq_n == 1, "R7 late enable", irq_n, 1);
    rd(8'h14, d); chk(d == 0, "R7 late enable status", d, 0);

    // R2: writes to status ignored
    wr(8'h14, 8'hFF); rd(8'h14, d); chk(d == 0, "R2 status write ignored", d, 0);
    chk(irq_n == 1, "R2 irq after status write", irq_n, 1);

    // R6: event in the same cycle as the clearing read
    fire(0);
    @(negedge clk);
    bus_addr = 8'h14; bus_rd = 1; los_lvl = ~los_lvl;
    #2 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
    chk(d == 8'h01, "R6 read value", d, 8'h01);
    chk(irq_n == 0, "R6 irq kept", irq_n, 0);
    rd(8'h14, d); chk(d == 8'h02, "R6 new bit kept", d, 8'h02);
    chk(irq_n == 1, "R6 irq after read", irq_n, 1);

    // R8: live-level register over all level combinations
    wr(8'h12, 8'h00);
    for (int c = 0; c < 32; c++) begin
      logic [7:0] e;
      @(negedge clk);
      {far_fail_lvl, oof_lvl, lof_lvl, los_lvl, ais_lvl} = 5'(c);
      e = {1'b0, c[2], c[3], c[1], c[0], 2'b00, c[4]};
      rd(8'h11, d); chk(d == e, "R8 live levels", d, e);
    end

    // R9: algorithm select
    wr(8'h11, 8'h80);
    chk(lof_alg_sel == 1, "R9 alg port", lof_alg_sel, 1);
    rd(8'h11, d); chk(d[7] == 1, "R9 alg readback", d[7], 1);
    wr(8'h11, 8'h00);
    chk(lof_alg_sel == 0, "R9 alg port clear", lof_alg_sel, 0);

    // R11: reset mid-run clears everything
    wr(8'h12, 8'h1F); wr(8'h11, 8'h80); fire(4);
    chk(irq_n == 0, "R11 pre-reset irq", irq_n, 0);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk(irq_n == 1, "R11 irq after reset", irq_n, 1);
    chk(lof_alg_sel == 0, "R11 alg after reset", lof_alg_sel, 0);
    rd(8'h12, d); chk(d == 0, "R11 enable after reset", d, 0);
    rd(8'h14, d); chk(d == 0, "R11 status after reset", d, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule